// File: doc/BRIEF.md
# Serial Status-Register Write Guard

This block is the slave-side logic that decides whether a status-register write received over SPI may change the device's protection bits. It oversamples the serial clock, chip-select, data input and hardware protect pin with the system clock. It captures bits on each rising edge of the serial clock while chip-select is low. An instruction is acted upon only when chip-select returns high, and only if the frame had exactly the right length.

A status write is a two-step sequence. First a one-byte arming instruction is sent in its own frame. The write instruction must follow in the very next frame. The write carries a data byte that can change four block-protect bits and one lock bit. While the lock bit is set, a low level on the protect pin blocks any further write. While the lock bit is clear, the protect pin cannot stop a write, and that write may set the lock bit itself. Both SPI modes 0 and 3 are accepted.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset, status_o is 8'h00 and arm_o is 0.
- R2: A frame of exactly 8 bits carrying 8'h50 sets arm_o to 1 once chip-select rises.
- R3: A frame of exactly 8 bits carrying 8'h06 sets arm_o to 1 once chip-select rises.
- R4: An accepted write is a frame of exactly 16 bits, sent MSB first: opcode 8'h01, then a data byte. It copies data bit 7 into status bit 7 (lock) and data bits 5..2 into status bits 5..2 (block protect). Status bits 6, 1 and 0 stay 0. arm_o returns to 0.
- R5: A write frame that does not immediately follow an arming frame leaves status_o unchanged.
- R6: With wp_n_i low and status bit 7 at 1 when chip-select rises, a write frame leaves status_o unchanged and clears arm_o.
- R7: With wp_n_i low and status bit 7 at 0, an armed write applies in full and may set bit 7 and bits 5..2 in the same frame.
- R8: With wp_n_i high, an armed write applies in full, including clearing bit 7.
- R9: Any other complete 8- or 16-bit frame clears arm_o, so a write sent after it is ignored.
- R10: A frame whose bit count is neither 8 nor 16 changes nothing except clearing arm_o. This includes an 8-bit frame holding only 8'h01, and any frame longer than 16 bits.
- R11: Frames sent in SPI mode 3 (serial clock idling high) behave the same as frames sent in mode 0.
- R12: status_o and arm_o do not change while chip-select stays low, even after a complete frame has been shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock; data is captured on its rising edge |
| cs_n_i | input | 1 | Active-low chip-select; its rising edge executes the frame |
| mosi_i | input | 1 | Serial data into the device, MSB first |
| wp_n_i | input | 1 | Active-low hardware protect pin |
| status_o | output | 8 | Status register: bit 7 lock, bits 5..2 block protect |
| arm_o | output | 1 | Set while a status write is armed |

## Verification
Three decisions fall on the same chip-select rising edge. The lock check reads the old lock bit, the new byte may rewrite that bit, and the arm flag is cleared. This is provoked with the protect pin low and the lock clear, using a write whose data sets the lock together with block-protect bits. The bench judges that this write takes effect and arm_o drops. A second armed write then arrives under the same pin level and must leave the status unchanged, which shows the lock was judged from the value held before each edge.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_ARM_STATUS = 8'h50;
   localparam logic [BYTE_W-1:0] OP_ARM_WRITE  = 8'h06;
   localparam logic [BYTE_W-1:0] OP_STATUS_WR  = 8'h01;

   // writable status bits: lock (7) and block protect (5..2)
   localparam logic [BYTE_W-1:0] SR_WR_MASK  = 8'hBC;
   localparam int unsigned       SR_LOCK_BIT = 7;

   typedef enum logic [1:0] {
      FK_NONE  = 2'd0,
      FK_ARM   = 2'd1,
      FK_WRITE = 2'd2,
      FK_OTHER = 2'd3
   } frame_kind_e;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_sr_rx.sv
module spi_sr_rx #(
   parameter int unsigned FRAME_BITS = 16,
   localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sck_s,
   input  logic                  cs_n_s,
   input  logic                  mosi_s,
   output logic [FRAME_BITS-1:0] shreg_o,
   output logic [CNT_W-1:0]      bit_cnt_o,
   output logic                  frame_end_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

   logic sck_d, cs_d;
   logic sck_rise;

   assign sck_rise    = sck_s & ~sck_d;
   assign frame_end_o = cs_n_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         cs_d      <= 1'b1;
         shreg_o   <= '0;
         bit_cnt_o <= '0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_n_s;
         if (cs_n_s) begin
            bit_cnt_o <= '0;
         end else if (sck_rise) begin
            shreg_o <= {shreg_o[FRAME_BITS-2:0], mosi_s};
            if (bit_cnt_o != CNT_SAT) bit_cnt_o <= bit_cnt_o + 1'b1;
         end
      end
   end

   // R10: an overlong frame saturates instead of wrapping back to a legal count
   a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt_o == CNT_SAT && !cs_n_s) |=> (bit_cnt_o == CNT_SAT || $rose(cs_n_s)));
   a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt_o <= CNT_SAT);
endmodule

// File: rtl/spi_sr_protect.sv
module spi_sr_protect
   import spi_sr_pkg::*;
#(
   parameter int unsigned OPC_W  = 8,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned FRAME_BITS = OPC_W + DATA_W,
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_end_i,
   input  logic [CNT_W-1:0]      bit_cnt_i,
   input  logic [FRAME_BITS-1:0] shreg_i,
   input  logic                  wp_n_s,
   output logic [DATA_W-1:0]     status_o,
   output logic                  arm_o
);
   generate
      if (OPC_W != BYTE_W || DATA_W != BYTE_W) begin : g_bad_width
         $error("spi_sr_protect: opcode and data must each be one byte");
      end
   endgenerate

   frame_kind_e      kind;
   logic [OPC_W-1:0] short_opc, long_opc;
   logic             locked, wr_ok;

   assign short_opc = shreg_i[OPC_W-1:0];
   assign long_opc  = shreg_i[FRAME_BITS-1 -: OPC_W];
   assign locked    = status_o[SR_LOCK_BIT] & ~wp_n_s;

   always_comb begin
      kind = FK_NONE;
      if (bit_cnt_i == CNT_W'(OPC_W)) begin
         kind = (short_opc == OP_ARM_STATUS || short_opc == OP_ARM_WRITE) ? FK_ARM : FK_OTHER;
      end else if (bit_cnt_i == CNT_W'(FRAME_BITS)) begin
         kind = (long_opc == OP_STATUS_WR) ? FK_WRITE : FK_OTHER;
      end
   end

   assign wr_ok = frame_end_i && kind == FK_WRITE && arm_o && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= '0;
         arm_o    <= 1'b0;
      end else if (frame_end_i) begin
         arm_o <= (kind == FK_ARM);
         if (wr_ok) status_o <= (status_o & ~SR_WR_MASK) | (shreg_i[DATA_W-1:0] & SR_WR_MASK);
      end
   end

   // R6: lock bit with protect pin low freezes the register
   a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && !wp_n_s && status_o[SR_LOCK_BIT]) |=> $stable(status_o));
   // R5: no write without a preceding arm
   a_r5_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && !arm_o) |=> $stable(status_o));
   // R12: nothing changes before chip-select rises
   a_r12_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_i |=> ($stable(status_o) && $stable(arm_o)));
   // R9: every executed frame other than an arm drops the arm flag
   a_r9_arm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && kind != FK_ARM) |=> !arm_o);
   // R4: read-only bits never leave zero
   a_r4_ro_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && wr_ok) |=> ((status_o & ~SR_WR_MASK) == '0));
endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OPC_W       = 8,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              mosi_i,
   input  logic              wp_n_i,
   output logic [DATA_W-1:0] status_o,
   output logic              arm_o
);
   localparam int unsigned FRAME_BITS = OPC_W + DATA_W;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);

   generate
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("spi_sr_guard: use 0 (inputs already synchronous) or at least 2 stages");
      end
   endgenerate

   logic [3:0]            pins_s;
   logic                  sck_s, cs_n_s, mosi_s, wp_n_s;
   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      bit_cnt;
   logic                  frame_end;

   spi_sr_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b1100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({wp_n_i, cs_n_i, sck_i, mosi_i}),
      .q_o   (pins_s)
   );
   assign {wp_n_s, cs_n_s, sck_s, mosi_s} = pins_s;

   spi_sr_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sck_s       (sck_s),
      .cs_n_s      (cs_n_s),
      .mosi_s      (mosi_s),
      .shreg_o     (shreg),
      .bit_cnt_o   (bit_cnt),
      .frame_end_o (frame_end)
   );

   spi_sr_protect #(.OPC_W(OPC_W), .DATA_W(DATA_W)) u_protect (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_end_i (frame_end),
      .bit_cnt_i   (bit_cnt),
      .shreg_i     (shreg),
      .wp_n_s      (wp_n_s),
      .status_o    (status_o),
      .arm_o       (arm_o)
   );
endmodule

// File: tb/spi_sr_guard_bench.sv
module spi_sr_guard_bench;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
   logic [7:0] status;
   logic       arm;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   spi_sr_guard u_spi_sr_guard (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n),
      .mosi_i(mosi), .wp_n_i(wp_n), .status_o(status), .arm_o(arm)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic frame_open(input bit m3);
      sck = m3;
      wait_clk(HALF);
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic frame_bits(input int n, input logic [23:0] val, input bit m3);
      for (int i = n - 1; i >= 0; i--) begin
         if (m3) sck = 1'b0;
         mosi = val[i];
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         if (!m3) sck = 1'b0;
      end
   endtask

   task automatic frame_close();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(10);
   endtask

   task automatic send(input int n, input logic [23:0] val, input bit m3 = 1'b0);
      frame_open(m3);
      frame_bits(n, val, m3);
      frame_close();
   endtask

   task automatic t_reset();
      check("R1 status", status, 8'h00);
      check("R1 arm", {7'b0, arm}, 8'h00);
   endtask

   task automatic t_arm_and_write();
      wp_n = 1'b1;
      send(8, 24'h50);
      check("R2 arm after 50", {7'b0, arm}, 8'h01);
      send(16, 24'h01FF);
      check("R4 writable bits only", status, 8'hBC);
      check("R4 arm cleared", {7'b0, arm}, 8'h00);
   endtask

   task automatic t_unarmed();
      send(16, 24'h0100);
      check("R5 unarmed write ignored", status, 8'hBC);
   endtask

   task automatic t_clear_lock_wp_high();
      wp_n = 1'b1;
      send(8, 24'h06);
      check("R3 arm after 06", {7'b0, arm}, 8'h01);
      send(16, 24'h0100);
      check("R8 lock cleared with pin high", status, 8'h00);
   endtask

   task automatic t_lock_wp_low();
      wp_n = 1'b0;
      send(8, 24'h50);
      send(16, 24'h0194);
      check("R7 lock and protect set together", status, 8'h94);
      check("R7 arm cleared", {7'b0, arm}, 8'h00);
      send(8, 24'h06);
      send(16, 24'h0100);
      check("R6 locked write ignored", status, 8'h94);
      check("R6 arm cleared", {7'b0, arm}, 8'h00);
   endtask

   task automatic t_other_clears();
      wp_n = 1'b1;
      send(8, 24'h50);
      send(8, 24'h03);
      check("R9 other opcode clears arm", {7'b0, arm}, 8'h00);
      send(16, 24'h0100);
      check("R9 write after other ignored", status, 8'h94);
      send(8, 24'h06);
      send(16, 24'h0300);
      check("R9 other 16-bit frame clears arm", {7'b0, arm}, 8'h00);
   endtask

   task automatic t_partial();
      wp_n = 1'b1;
      send(8, 24'h50);
      send(5, 24'h01);
      check("R10 short frame clears arm", {7'b0, arm}, 8'h00);
      send(8, 24'h50);
      send(8, 24'h01);
      check("R10 write without data clears arm", {7'b0, arm}, 8'h00);
      check("R10 write without data keeps status", status, 8'h94);
      send(8, 24'h06);
      send(12, 24'h010);
      check("R10 12-bit frame keeps status", status, 8'h94);
      send(8, 24'h06);
      send(17, 24'h00200);
      check("R10 17-bit frame keeps status", status, 8'h94);
      check("R10 17-bit frame clears arm", {7'b0, arm}, 8'h00);
   endtask

   task automatic t_mode3();
      wp_n = 1'b1;
      send(8, 24'h06, 1'b1);
      check("R11 mode 3 arm", {7'b0, arm}, 8'h01);
      send(16, 24'h0124, 1'b1);
      check("R11 mode 3 write", status, 8'h24);
   endtask

   task automatic t_pending();
      send(8, 24'h50);
      frame_open(1'b0);
      frame_bits(16, 24'h0108, 1'b0);
      wait_clk(12);
      check("R12 status held while selected", status, 8'h24);
      check("R12 arm held while selected", {7'b0, arm}, 8'h01);
      frame_close();
      check("R12 applied at chip-select rise", status, 8'h08);
   endtask

   initial begin
      wait_clk(3);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_arm_and_write();
      t_unarmed();
      t_clear_lock_wp_high();
      t_lock_wp_low();
      t_other_clears();
      t_partial();
      t_mode3();
      t_pending();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule